// File: doc/BRIEF.md
# Serial Flash Controller Configuration Register Bank

This block is the software-visible register file of a serial flash controller. A host reaches it over a simple word-aligned bus. It holds the settings for memory-mapped reads, memory-mapped writes and host-driven command transactions. It also holds the command byte, the address, the outgoing data words and the returned data words of a host-driven transaction, a group of protection words kept only as plain storage, and a global configuration word. Configuration words come out as ports so that the serial engine can use them.

Two kinds of lock guard the configuration. Bit 31 of the global word freezes the three transaction configuration words as a whole. Bit 30 of the command-transaction configuration word freezes selected fields of that word. The control/status word carries an execute bit that starts a transaction, a ready flag that software clears by writing one to it, and a software chip-select bit. Changes to the chip-select bit drive the active-low chip-select outputs directly. An execute raises a request toward a transaction sequencer, which answers with an acknowledge and later with a completion pulse that carries the returned data.

Top module: `sflash_cfg_bank`

## Requirements
- R1: While bit 31 of the global configuration word (offset 0x78) is 1, bus writes to offsets 0x00, 0x04 and 0x08 leave those words unchanged. When that bit is 0, the writes take effect.
- R2: While bit 30 of the word at 0x08 is 1, a write to 0x08 keeps the old value of the bits in mask 0x00000403 and updates every other bit.
- R3: In the control/status word (0x0C), bit 24 is set by a sequencer completion. Writing 1 to bit 24 clears it, and writing 0 to it leaves it as it was.
- R4: Writing 1 to bit 0 of 0x0C sets that bit. A later write of 0 does not clear it. Only a sequencer completion clears it.
- R5: When a write changes bit 16 of 0x0C from 1 to 0, the chip-select output given by bits 9:8 of the written value goes low at once, and all other chip-select outputs are high. If that index is at least NUM_CS, no output is driven low.
- R6: When a write changes bit 16 from 0 to 1, all chip-select outputs go high. The exception is when bit 0 is already set or is set by that same write; then the chip-select outputs keep their state.
- R7: The four words at 0x30, 0x34, 0x38 and 0x3C are read-only and ignore bus writes. On a completion they load seq_rd_data, with word k taken from bits 32k+31:32k.
- R8: After reset the words read as follows: 0x00 = 0x0300100B, 0x04 = 0x03000002, 0x08 = 0x00000400, 0x0C = 0x00010000, 0x10 = 0x0000000B, 0x78 = 0x0000000B. All other words read 0, all chip-select outputs are high, and seq_req is low.
- R9: Reads from unmapped offsets (0x1C, 0x68 to 0x74, 0x7C) return zero, and writes to them have no effect.
- R10: An execute write made while bit 0 is 0 raises seq_req from the next clock edge. seq_req stays high until a cycle in which seq_ack is high, and drops at that edge. A seq_done pulse is the completion.
- R11: bus_rdata presents the addressed word on the cycle after a read request. Words 0x10, 0x14, 0x18, 0x20 to 0x2C and 0x40 to 0x64 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access request |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| cs_n | output | NUM_CS | Active-low chip selects |
| seq_req | output | 1 | Start request to the sequencer |
| seq_ack | input | 1 | Sequencer accepted the request |
| seq_done | input | 1 | One-cycle completion pulse |
| seq_rd_data | input | 32*RD_N | Returned data, loaded on seq_done |
| drd_cfg | output | 32 | Memory-mapped read configuration |
| dwr_cfg | output | 32 | Memory-mapped write configuration |
| uma_cfg | output | 32 | Command transaction configuration |
| uma_cmd | output | 32 | Command word |
| uma_addr | output | 32 | Transaction address |
| uma_wdata | output | 32*WD_N | Outgoing data words |

## Verification
The hardest case to reach is the rule that a rising software chip-select bit leaves the chip select alone while an execute is pending. To reach it, the bench first drops bit 16 so that a device is selected. It then writes bit 16 and bit 0 together in one word, so that the release and the start fall on the same edge. It checks that the select stays low, then completes the transaction through the acknowledge and done pulses and releases with a plain write. The combined-lock cases are reached with a similar ordered series of writes: set bit 30 first, then attempt writes to the masked bits and to the lock bit itself.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int WORD_W = 32;

  // word indices (byte offset / 4)
  localparam int IX_DRD  = 0;
  localparam int IX_DWR  = 1;
  localparam int IX_UCFG = 2;
  localparam int IX_CTS  = 3;
  localparam int IX_CMD  = 4;
  localparam int IX_ADR  = 5;
  localparam int IX_PCFG = 6;
  localparam int WD_BASE = 8;
  localparam int RD_BASE = 12;
  localparam int PCMD_BASE = 16;
  localparam int IX_GCFG = 30;

  // field positions
  localparam int GLOCK_BIT  = 31;
  localparam int CMLOCK_BIT = 30;
  localparam logic [WORD_W-1:0] CMLOCK_MASK = 32'h0000_0403;
  localparam int RDY_BIT  = 24;
  localparam int SWCS_BIT = 16;
  localparam int DEV_LO   = 8;
  localparam int EXEC_BIT = 0;

  // reset values
  localparam logic [WORD_W-1:0] RST_DRD  = 32'h0300_100B;
  localparam logic [WORD_W-1:0] RST_DWR  = 32'h0300_0002;
  localparam logic [WORD_W-1:0] RST_UCFG = 32'h0000_0400;
  localparam logic [WORD_W-1:0] RST_CTS  = 32'h0001_0000;
  localparam logic [WORD_W-1:0] RST_CMD  = 32'h0000_000B;
  localparam logic [WORD_W-1:0] RST_GCFG = 32'h0000_000B;

  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sfc_lock_filter.sv
module sfc_lock_filter
  import sfc_pkg::*;
(
  input  logic       glock,
  input  logic [2:0] hit_in,     // {ucfg, dwr, drd} write hits
  output logic [2:0] en_out,
  input  word_t      ucfg_cur,
  input  word_t      wdata,
  output word_t      ucfg_next
);
  // the global lock gates all three configuration words at once
  assign en_out = glock ? 3'b000 : hit_in;

  // the sub-lock keeps the protected fields and lets the rest through
  always_comb begin
    if (ucfg_cur[CMLOCK_BIT])
      ucfg_next = (wdata & ~CMLOCK_MASK) | (ucfg_cur & CMLOCK_MASK);
    else
      ucfg_next = wdata;
  end
endmodule

// File: rtl/sfc_word_array.sv
module sfc_word_array
  import sfc_pkg::*;
#(
  parameter int N     = 4,
  parameter int BASE  = 8,
  parameter int IDX_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       widx,
  input  word_t                  wdata,
  output logic [N-1:0][WORD_W-1:0] words
);
  for (genvar i = 0; i < N; i++) begin : g_word
    localparam logic [IDX_W-1:0] MY_IX = IDX_W'(BASE + i);
    always_ff @(posedge clk) begin
      if (rst)
        words[i] <= '0;
      else if (wr_en && widx == MY_IX)
        words[i] <= wdata;
    end
  end
endmodule

// File: rtl/sfc_ctl_status.sv
module sfc_ctl_status
  import sfc_pkg::*;
#(
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  word_t             wdata,
  input  logic              seq_ack,
  input  logic              seq_done,
  output word_t             cts,
  output logic              seq_req,
  output logic [NUM_CS-1:0] cs_n
);
  word_t cts_nx;
  logic  start;
  logic  cs_fall, cs_rise;
  logic [1:0] dev;

  assign dev     = wdata[DEV_LO+1:DEV_LO];
  assign start   = wr_en && wdata[EXEC_BIT] && !cts[EXEC_BIT];
  assign cs_fall = wr_en && cts[SWCS_BIT] && !wdata[SWCS_BIT];
  assign cs_rise = wr_en && !cts[SWCS_BIT] && wdata[SWCS_BIT]
                   && !(wdata[EXEC_BIT] || cts[EXEC_BIT]);

  always_comb begin
    cts_nx = cts;
    if (wr_en) begin
      cts_nx = wdata;
      cts_nx[RDY_BIT]  = wdata[RDY_BIT] ? 1'b0 : cts[RDY_BIT];
      cts_nx[EXEC_BIT] = cts[EXEC_BIT] | wdata[EXEC_BIT];
    end
    if (seq_done) begin
      cts_nx[RDY_BIT]  = 1'b1;
      cts_nx[EXEC_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cts     <= RST_CTS;
      seq_req <= 1'b0;
    end else begin
      cts <= cts_nx;
      if (start)        seq_req <= 1'b1;
      else if (seq_ack) seq_req <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst)          cs_n[i] <= 1'b1;
      else if (cs_fall) cs_n[i] <= !(int'(dev) == i);
      else if (cs_rise) cs_n[i] <= 1'b1;
    end
  end

  // R4
  exec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cts[EXEC_BIT] && !seq_done) |=> cts[EXEC_BIT]);
  // R3
  rdy_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cts[RDY_BIT] && !(wr_en && wdata[RDY_BIT])) |=> cts[RDY_BIT]);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_req && !seq_ack) |=> seq_req);
  // R5
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  // R6
  cs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cts[EXEC_BIT] && !cs_fall) |=> $stable(cs_n));
endmodule

// File: rtl/sflash_cfg_bank.sv
module sflash_cfg_bank
  import sfc_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int NUM_CS = 2,
  parameter int WD_N   = 4,
  parameter int RD_N   = 4,
  parameter int PROT_N = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_en,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [WORD_W-1:0]      bus_wdata,
  output logic [WORD_W-1:0]      bus_rdata,
  output logic [NUM_CS-1:0]      cs_n,
  output logic                   seq_req,
  input  logic                   seq_ack,
  input  logic                   seq_done,
  input  logic [RD_N*WORD_W-1:0] seq_rd_data,
  output logic [WORD_W-1:0]      drd_cfg,
  output logic [WORD_W-1:0]      dwr_cfg,
  output logic [WORD_W-1:0]      uma_cfg,
  output logic [WORD_W-1:0]      uma_cmd,
  output logic [WORD_W-1:0]      uma_addr,
  output logic [WD_N*WORD_W-1:0] uma_wdata
);
  localparam int IDX_W = ADDR_W - 2;

  logic             wr;
  logic [IDX_W-1:0] widx;
  assign wr   = bus_en && bus_we;
  assign widx = bus_addr[ADDR_W-1:2];

  function automatic logic hit(input int ix);
    return widx == IDX_W'(ix);
  endfunction

  word_t drd_q, dwr_q, ucfg_q, cmd_q, adr_q, pcfg_q, gcfg_q, cts_q, ucfg_nx;
  logic [RD_N-1:0][WORD_W-1:0]   rd_q;
  logic [WD_N-1:0][WORD_W-1:0]   wd_w;
  logic [PROT_N-1:0][WORD_W-1:0] pc_w;
  logic [2:0] cfg_en;

  sfc_lock_filter u_lock (
    .glock     (gcfg_q[GLOCK_BIT]),
    .hit_in    ({hit(IX_UCFG), hit(IX_DWR), hit(IX_DRD)} & {3{wr}}),
    .en_out    (cfg_en),
    .ucfg_cur  (ucfg_q),
    .wdata     (bus_wdata),
    .ucfg_next (ucfg_nx)
  );

  sfc_ctl_status #(.NUM_CS(NUM_CS)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr && hit(IX_CTS)),
    .wdata    (bus_wdata),
    .seq_ack  (seq_ack),
    .seq_done (seq_done),
    .cts      (cts_q),
    .seq_req  (seq_req),
    .cs_n     (cs_n)
  );

  sfc_word_array #(.N(WD_N), .BASE(WD_BASE), .IDX_W(IDX_W)) u_wdata (
    .clk (clk), .rst (rst), .wr_en (wr), .widx (widx),
    .wdata (bus_wdata), .words (wd_w)
  );

  sfc_word_array #(.N(PROT_N), .BASE(PCMD_BASE), .IDX_W(IDX_W)) u_prot (
    .clk (clk), .rst (rst), .wr_en (wr), .widx (widx),
    .wdata (bus_wdata), .words (pc_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drd_q  <= RST_DRD;
      dwr_q  <= RST_DWR;
      ucfg_q <= RST_UCFG;
      cmd_q  <= RST_CMD;
      adr_q  <= '0;
      pcfg_q <= '0;
      gcfg_q <= RST_GCFG;
      rd_q   <= '0;
    end else begin
      if (cfg_en[0]) drd_q  <= bus_wdata;
      if (cfg_en[1]) dwr_q  <= bus_wdata;
      if (cfg_en[2]) ucfg_q <= ucfg_nx;
      if (wr && hit(IX_CMD))  cmd_q  <= bus_wdata;
      if (wr && hit(IX_ADR))  adr_q  <= bus_wdata;
      if (wr && hit(IX_PCFG)) pcfg_q <= bus_wdata;
      if (wr && hit(IX_GCFG)) gcfg_q <= bus_wdata;
      if (seq_done)           rd_q   <= seq_rd_data;
    end
  end

  word_t rmux;
  always_comb begin
    int wi;
    wi   = int'(widx);
    rmux = '0;
    if (wi == IX_DRD)       rmux = drd_q;
    else if (wi == IX_DWR)  rmux = dwr_q;
    else if (wi == IX_UCFG) rmux = ucfg_q;
    else if (wi == IX_CTS)  rmux = cts_q;
    else if (wi == IX_CMD)  rmux = cmd_q;
    else if (wi == IX_ADR)  rmux = adr_q;
    else if (wi == IX_PCFG) rmux = pcfg_q;
    else if (wi == IX_GCFG) rmux = gcfg_q;
    else if (wi >= WD_BASE && wi < WD_BASE + WD_N)
      rmux = wd_w[wi - WD_BASE];
    else if (wi >= RD_BASE && wi < RD_BASE + RD_N)
      rmux = rd_q[wi - RD_BASE];
    else if (wi >= PCMD_BASE && wi < PCMD_BASE + PROT_N)
      rmux = pc_w[wi - PCMD_BASE];
  end

  always_ff @(posedge clk) begin
    if (rst)                  bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= rmux;
  end

  assign drd_cfg   = drd_q;
  assign dwr_cfg   = dwr_q;
  assign uma_cfg   = ucfg_q;
  assign uma_cmd   = cmd_q;
  assign uma_addr  = adr_q;
  assign uma_wdata = wd_w;

  // R1
  glock_drd_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && hit(IX_DRD) && gcfg_q[GLOCK_BIT]) |=> $stable(drd_q));
  // R1
  glock_ucfg_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && hit(IX_UCFG) && gcfg_q[GLOCK_BIT]) |=> $stable(ucfg_q));
  // R2
  cmlock_chk: assert property (@(posedge clk) disable iff (rst)
    (ucfg_q[CMLOCK_BIT]) |=> ((ucfg_q & CMLOCK_MASK) == ($past(ucfg_q) & CMLOCK_MASK)));
  // R7
  rd_ro_chk: assert property (@(posedge clk) disable iff (rst)
    !seq_done |=> $stable(rd_q));
endmodule

// File: tb/sflash_cfg_bank_tb_top.sv
module sflash_cfg_bank_tb_top;
  localparam int ADDR_W = 7;
  localparam int NUM_CS = 2;
  localparam int WD_N = 4;
  localparam int RD_N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic              bus_en = 0, bus_we = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0, bus_rdata;
  logic [NUM_CS-1:0] cs_n;
  logic              seq_req, seq_ack = 0, seq_done = 0;
  logic [RD_N*32-1:0] seq_rd_data = '0;
  logic [31:0] drd_cfg, dwr_cfg, uma_cfg, uma_cmd, uma_addr;
  logic [WD_N*32-1:0] uma_wdata;

  sflash_cfg_bank #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .WD_N(WD_N), .RD_N(RD_N)) dut_i (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cs_n(cs_n), .seq_req(seq_req),
    .seq_ack(seq_ack), .seq_done(seq_done), .seq_rd_data(seq_rd_data),
    .drd_cfg(drd_cfg), .dwr_cfg(dwr_cfg), .uma_cfg(uma_cfg), .uma_cmd(uma_cmd),
    .uma_addr(uma_addr), .uma_wdata(uma_wdata)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rdchk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_en = 0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic ack_pulse();
    seq_ack = 1; @(posedge clk); @(negedge clk); seq_ack = 0;
  endtask

  task automatic done_pulse(input logic [RD_N*32-1:0] d);
    seq_rd_data = d; seq_done = 1; @(posedge clk); @(negedge clk); seq_done = 0;
  endtask

  task automatic t_reset();
    rdchk("R8 drd", 7'h00, 32'h0300100B);
    rdchk("R8 dwr", 7'h04, 32'h03000002);
    rdchk("R8 ucfg", 7'h08, 32'h00000400);
    rdchk("R8 cts", 7'h0C, 32'h00010000);
    rdchk("R8 cmd", 7'h10, 32'h0000000B);
    rdchk("R8 gcfg", 7'h78, 32'h0000000B);
    rdchk("R8 rdata0", 7'h30, 32'h0);
    chk("R8 cs_n", 32'(cs_n), 32'h3);
    chk("R8 seq_req", 32'(seq_req), 32'h0);
  endtask

  task automatic t_global_lock();
    wr(7'h00, 32'h12345678);
    rdchk("R1 unlocked write", 7'h00, 32'h12345678);
    wr(7'h78, 32'h8000000B);
    wr(7'h00, 32'hDEADBEEF);
    wr(7'h04, 32'hDEADBEEF);
    wr(7'h08, 32'hDEADBEEF);
    rdchk("R1 locked drd", 7'h00, 32'h12345678);
    rdchk("R1 locked dwr", 7'h04, 32'h03000002);
    rdchk("R1 locked ucfg", 7'h08, 32'h00000400);
    wr(7'h78, 32'h0000000B);
    wr(7'h04, 32'h00000055);
    rdchk("R1 released dwr", 7'h04, 32'h00000055);
  endtask

  task automatic t_cmd_lock();
    wr(7'h08, 32'h40000000);
    rdchk("R2 set sublock", 7'h08, 32'h40000000);
    wr(7'h08, 32'h4FFFFFFF);
    rdchk("R2 masked bits held", 7'h08, 32'h4FFFFBFC);
    wr(7'h08, 32'h00000403);
    rdchk("R2 drop sublock", 7'h08, 32'h00000000);
    wr(7'h08, 32'h00000403);
    rdchk("R2 after release", 7'h08, 32'h00000403);
  endtask

  task automatic t_exec();
    wr(7'h0C, 32'h00010001);
    chk("R10 req raised", 32'(seq_req), 32'h1);
    rdchk("R4 exec set", 7'h0C, 32'h00010001);
    repeat (3) @(negedge clk);
    chk("R10 req held", 32'(seq_req), 32'h1);
    wr(7'h0C, 32'h00010000);
    rdchk("R4 exec not cleared", 7'h0C, 32'h00010001);
    ack_pulse();
    chk("R10 req dropped", 32'(seq_req), 32'h0);
    done_pulse({32'hD3D3D3D3, 32'hC2C2C2C2, 32'hB1B1B1B1, 32'hA0A0A0A0});
    rdchk("R3 ready set exec clear", 7'h0C, 32'h01010000);
    rdchk("R7 rdata0", 7'h30, 32'hA0A0A0A0);
    rdchk("R7 rdata3", 7'h3C, 32'hD3D3D3D3);
    wr(7'h0C, 32'h00010000);
    rdchk("R3 write0 keeps", 7'h0C, 32'h01010000);
    wr(7'h0C, 32'h01010000);
    rdchk("R3 write1 clears", 7'h0C, 32'h00010000);
  endtask

  task automatic t_readonly();
    wr(7'h30, 32'hFFFFFFFF);
    wr(7'h38, 32'h00000000);
    rdchk("R7 ro word0", 7'h30, 32'hA0A0A0A0);
    rdchk("R7 ro word2", 7'h38, 32'hC2C2C2C2);
  endtask

  task automatic t_cs();
    wr(7'h0C, 32'h00000100);
    chk("R5 select dev1", 32'(cs_n), 32'h1);
    wr(7'h0C, 32'h00010100);
    chk("R6 release", 32'(cs_n), 32'h3);
    wr(7'h0C, 32'h00000300);
    chk("R5 out of range", 32'(cs_n), 32'h3);
    wr(7'h0C, 32'h00010300);
    wr(7'h0C, 32'h00000000);
    chk("R5 select dev0", 32'(cs_n), 32'h2);
    wr(7'h0C, 32'h00010001);
    chk("R6 held by execute", 32'(cs_n), 32'h2);
    ack_pulse();
    done_pulse('0);
    chk("R6 held after done", 32'(cs_n), 32'h2);
    wr(7'h0C, 32'h00000000);
    wr(7'h0C, 32'h00010000);
    chk("R6 release after done", 32'(cs_n), 32'h3);
  endtask

  task automatic t_plain();
    wr(7'h10, 32'h11110001);
    wr(7'h14, 32'h22220002);
    wr(7'h18, 32'h33330003);
    wr(7'h2C, 32'h44440004);
    wr(7'h64, 32'h55550005);
    rdchk("R11 cmd", 7'h10, 32'h11110001);
    rdchk("R11 addr", 7'h14, 32'h22220002);
    rdchk("R11 prot cfg", 7'h18, 32'h33330003);
    rdchk("R11 wdata3", 7'h2C, 32'h44440004);
    rdchk("R11 prot cmd9", 7'h64, 32'h55550005);
    chk("R11 cmd port", uma_cmd, 32'h11110001);
  endtask

  task automatic t_unmapped();
    wr(7'h1C, 32'hAAAA5555);
    wr(7'h7C, 32'h12121212);
    rdchk("R9 hole 0x1C", 7'h1C, 32'h0);
    rdchk("R9 hole 0x7C", 7'h7C, 32'h0);
    rdchk("R9 hole 0x70", 7'h70, 32'h0);
    rdchk("R9 neighbour intact", 7'h18, 32'h33330003);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_global_lock();
    t_cmd_lock();
    t_exec();
    t_readonly();
    t_cs();
    t_plain();
    t_unmapped();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule